// File: doc/BRIEF.md
# Timing Link Frame Decoder

This block sits behind an 8b/10b receiver that delivers one 16-bit word per receive clock, together with a 2-bit flag that marks which byte of the word is a control character. The two bytes of a word carry separate channels. The low byte carries event codes and comma characters. The high byte carries a slower data channel, in which framed payload bytes sit between an opening and a closing control character and are followed by a 16-bit checksum.

The decoder compares every event code against four programmable slots. It pulses one output bit for each slot that matches. It also collects frame payload bytes into a buffer with two banks. A frame becomes visible to the host only when its checksum is correct. The host side runs on its own clock and reads the latest accepted frame as 32-bit words through a 12-bit word address. A new frame replaces the old one in a single step, so the host never sees part of one frame mixed with part of another.

Top module: `tlink_frame_decoder`

## Requirements
- R1: While `rx_los` is high, `evt_hit` and `frame_err` stay 0. After reset, every host address reads 0 until a frame is accepted.
- R2: A low byte whose flag bit 0 is set never produces an event hit. This covers the comma 0xBC and any other value, including one that equals a programmed slot number.
- R3: A non-zero low byte with flag bit 0 clear is an event code. Each enabled slot whose 8-bit number (slot s sits in `evt_num[8s+7:8s]`) equals the code sets `evt_hit[s]` for exactly one receive clock, in the cycle after the word. Several slots can fire together. The code 0x00 never fires.
- R4: A slot whose bit in `evt_en` is 0 never fires, even when its number matches.
- R5: A high byte of 0x5C with flag bit 1 set opens a frame. This holds on any word, and an open frame restarts with its bytes discarded. The data channel then takes one high byte on every second word, at offsets 2, 4, 6 and so on from the opening word. High bytes at odd offsets are ignored.
- R6: Inside a frame, 0x3C with flag bit 1 on a data slot closes the frame. The next two non-control data-slot bytes are the checksum, most significant byte first. The frame is accepted when the checksum equals 0xFFFF minus the 16-bit sum of its payload bytes.
- R7: On a checksum mismatch, `frame_err` is high for exactly one receive clock and the contents the host sees do not change.
- R8: Payload byte k of the accepted frame is read at word address 8 + k/4, in bits 8*(k%4)+7 down to 8*(k%4). Byte positions past the frame length read 0. Addresses below 8, and addresses at or above 8 + MAX_BYTES/4, read 0.
- R9: A frame that reaches a payload byte beyond MAX_BYTES (64) is aborted with a one-clock `frame_err`, and the host view does not change. A frame of exactly 64 bytes is accepted.
- R10: `host_data` shows the word at `host_addr` after two rising edges of `usr_clk`. After only one edge it still shows the word at the previous address.
- R11: An accepted frame becomes readable by the host a few user clocks after its last checksum byte, and it replaces the previous frame as a whole.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rx_clk | input | 1 | Receive word clock |
| rx_los | input | 1 | Loss of signal; holds the receive side in reset while high |
| rx_word | input | 16 | Received word: high byte data channel, low byte events |
| rx_kflag | input | 2 | Control-character flags; bit 1 for the high byte, bit 0 for the low byte |
| evt_num | input | 32 | Four 8-bit slot numbers, slot s at bits 8s+7:8s |
| evt_en | input | 4 | Per-slot enable |
| evt_hit | output | 4 | One-clock match pulse per slot |
| frame_err | output | 1 | One-clock pulse on checksum mismatch or overlong frame |
| usr_clk | input | 1 | Host clock |
| usr_rst | input | 1 | Host-side reset, active high |
| host_addr | input | 12 | Host word address |
| host_data | output | 32 | Host read data |

## Verification
Several properties are checked on every receive cycle: a control-flagged low byte is followed by a quiet `evt_hit`, a hit only follows an enabled slot, an error pulse never lasts two cycles and never follows an accepted frame, and the checksum phase is only entered from the payload phase. On the host clock, an address outside the payload window always returns zero on the next cycle. The bench scenarios are the only place where the payload phase rule, the little-endian packing, the clearing of stale bytes, a restart inside a frame, the 64-byte boundary and the atomic replacement of the visible frame can be shown. Each of these needs a whole frame sent and the result read back on the host clock.

// File: rtl/tlink_pkg.sv
package tlink_pkg;
   localparam logic [7:0] K_FRAME_OPEN = 8'h5C;
   localparam logic [7:0] K_FRAME_SHUT = 8'h3C;
   localparam logic [7:0] K_COMMA      = 8'hBC;

   typedef enum logic [1:0] {
      FS_IDLE,
      FS_BODY,
      FS_SUM_HI,
      FS_SUM_LO
   } frame_state_e;
endpackage

// File: rtl/tlink_evt_match.sv
module tlink_evt_match #(
   parameter int SLOTS  = 4,
   parameter int CODE_W = 8
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [CODE_W-1:0]        code,
   input  logic                     code_is_k,
   input  logic [SLOTS*CODE_W-1:0]  slot_num,
   input  logic [SLOTS-1:0]         slot_en,
   output logic [SLOTS-1:0]         hit
);
   if (SLOTS < 1) begin : g_bad_slots
      $error("tlink_evt_match: SLOTS must be at least 1");
   end

   logic code_ok;
   assign code_ok = !code_is_k && (code != '0);

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic hit_q;
      always_ff @(posedge clk) begin
         if (rst) hit_q <= 1'b0;
         else     hit_q <= slot_en[s] && code_ok &&
                           (slot_num[s*CODE_W +: CODE_W] == code);
      end
      assign hit[s] = hit_q;

      // R4: a hit only follows a cycle in which the slot was enabled
      p_slot_gate_r4: assert property (@(posedge clk) disable iff (rst)
         hit[s] |-> $past(slot_en[s]));
   end

   // R2: a control-flagged low byte leaves every hit bit low next cycle
   p_kcode_quiet_r2: assert property (@(posedge clk) disable iff (rst)
      code_is_k |=> (hit == '0));
endmodule

// File: rtl/tlink_frame_parser.sv
module tlink_frame_parser
   import tlink_pkg::*;
#(
   parameter int MAX_BYTES = 64,
   parameter int BYTE_W    = $clog2(MAX_BYTES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [7:0]        hi_byte,
   input  logic              hi_is_k,
   output logic              clr_o,
   output logic              wr_o,
   output logic [BYTE_W-1:0] idx_o,
   output logic [7:0]        byte_o,
   output logic              commit_o,
   output logic              err_o
);
   localparam int CNT_W = $clog2(MAX_BYTES + 1);
   localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_BYTES);

   frame_state_e     st;
   logic             odd;
   logic [CNT_W-1:0] cnt;
   logic [15:0]      sum;
   logic [7:0]       sum_hi;
   logic             err_q;

   logic is_open, slot, in_body, ovf, shut, chk_done, bad;

   always_comb begin
      is_open  = hi_is_k && (hi_byte == K_FRAME_OPEN);
      slot     = (st != FS_IDLE) && !odd && !is_open;
      in_body  = slot && (st == FS_BODY);
      wr_o     = in_body && !hi_is_k && (cnt < CAP);
      ovf      = in_body && !hi_is_k && (cnt == CAP);
      shut     = in_body && hi_is_k && (hi_byte == K_FRAME_SHUT);
      chk_done = slot && (st == FS_SUM_LO) && !hi_is_k;
      commit_o = chk_done && ({sum_hi, hi_byte} == ~sum);
      bad      = ovf || (chk_done && !commit_o);
      clr_o    = is_open;
      idx_o    = cnt[BYTE_W-1:0];
      byte_o   = hi_byte;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= FS_IDLE;
         odd    <= 1'b0;
         cnt    <= '0;
         sum    <= '0;
         sum_hi <= '0;
         err_q  <= 1'b0;
      end else begin
         err_q <= bad;
         odd   <= is_open ? 1'b1 : ~odd;
         if (is_open) begin
            st  <= FS_BODY;
            cnt <= '0;
            sum <= '0;
         end else if (slot) begin
            case (st)
               FS_BODY: begin
                  if (shut)      st <= FS_SUM_HI;
                  else if (ovf)  st <= FS_IDLE;
                  else if (wr_o) begin
                     cnt <= cnt + 1'b1;
                     sum <= sum + 16'(hi_byte);
                  end
               end
               FS_SUM_HI: if (!hi_is_k) begin
                  sum_hi <= hi_byte;
                  st     <= FS_SUM_LO;
               end
               FS_SUM_LO: if (!hi_is_k) st <= FS_IDLE;
               default: st <= FS_IDLE;
            endcase
         end
      end
   end

   assign err_o = err_q;

   // R7: the error flag is a single-cycle pulse
   p_err_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      err_q |=> !err_q);
   // R7: an accepted frame is never followed by an error pulse
   p_commit_clean_r7: assert property (@(posedge clk) disable iff (rst)
      commit_o |=> !err_q);
   // R6: the checksum phase is entered only from the payload phase
   p_sum_entry_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(st == FS_SUM_HI) |-> ($past(st) == FS_BODY));
endmodule

// File: rtl/tlink_pingpong_buf.sv
module tlink_pingpong_buf #(
   parameter int MAX_BYTES   = 64,
   parameter int HOST_AW     = 12,
   parameter int BASE_WORD   = 8,
   parameter int SYNC_STAGES = 2,
   parameter int BYTE_W      = $clog2(MAX_BYTES)
) (
   input  logic               wclk,
   input  logic               wrst,
   input  logic               clr_i,
   input  logic               wr_i,
   input  logic [BYTE_W-1:0]  idx_i,
   input  logic [7:0]         byte_i,
   input  logic               commit_i,
   input  logic               rclk,
   input  logic               rrst,
   input  logic [HOST_AW-1:0] raddr_i,
   output logic [31:0]        rdata_o
);
   localparam int WORDS = MAX_BYTES / 4;
   localparam logic [HOST_AW-1:0] BASE_A  = HOST_AW'(BASE_WORD);
   localparam logic [HOST_AW-1:0] WORDS_A = HOST_AW'(WORDS);

   if (MAX_BYTES % 4 != 0 || MAX_BYTES < 4) begin : g_bad_bytes
      $error("tlink_pingpong_buf: MAX_BYTES must be a positive multiple of 4");
   end
   if (BASE_WORD + WORDS > (1 << HOST_AW)) begin : g_bad_map
      $error("tlink_pingpong_buf: payload window exceeds host address space");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tlink_pingpong_buf: SYNC_STAGES must be at least 2");
   end

   logic [7:0] mem [2][MAX_BYTES];
   logic       shown;
   logic       wbank;
   assign wbank = ~shown;

   always_ff @(posedge wclk) begin
      if (wrst) begin
         shown <= 1'b0;
         for (int b = 0; b < 2; b++)
            for (int j = 0; j < MAX_BYTES; j++) mem[b][j] <= '0;
      end else begin
         if (commit_i) shown <= ~shown;
         if (clr_i) begin
            for (int j = 0; j < MAX_BYTES; j++) mem[wbank][j] <= '0;
         end else if (wr_i) begin
            mem[wbank][idx_i] <= byte_i;
         end
      end
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rbank;
   logic [HOST_AW-1:0]     addr_q;
   logic [HOST_AW-1:0]     off;
   logic                   hit;
   logic [31:0]            word;
   logic [31:0]            rdata_q;

   always_ff @(posedge rclk) begin
      if (rrst) sync_q <= '0;
      else      sync_q <= {sync_q[SYNC_STAGES-2:0], shown};
   end
   assign rbank = sync_q[SYNC_STAGES-1];

   always_comb begin
      off  = addr_q - BASE_A;
      hit  = (addr_q >= BASE_A) && (off < WORDS_A);
      word = '0;
      if (hit) begin
         for (int l = 0; l < 4; l++)
            word[8*l +: 8] = mem[rbank][BYTE_W'(int'(off) * 4 + l)];
      end
   end

   always_ff @(posedge rclk) begin
      if (rrst) begin
         addr_q  <= '0;
         rdata_q <= '0;
      end else begin
         addr_q  <= raddr_i;
         rdata_q <= word;
      end
   end
   assign rdata_o = rdata_q;

   // R8: addresses outside the payload window return zero
   p_outside_zero_r8: assert property (@(posedge rclk) disable iff (rrst)
      !hit |=> (rdata_q == '0));
endmodule

// File: rtl/tlink_frame_decoder.sv
module tlink_frame_decoder #(
   parameter int SLOTS     = 4,
   parameter int MAX_BYTES = 64,
   parameter int HOST_AW   = 12,
   parameter int BASE_WORD = 8
) (
   input  logic                 rx_clk,
   input  logic                 rx_los,
   input  logic [15:0]          rx_word,
   input  logic [1:0]           rx_kflag,
   input  logic [SLOTS*8-1:0]   evt_num,
   input  logic [SLOTS-1:0]     evt_en,
   output logic [SLOTS-1:0]     evt_hit,
   output logic                 frame_err,
   input  logic                 usr_clk,
   input  logic                 usr_rst,
   input  logic [HOST_AW-1:0]   host_addr,
   output logic [31:0]          host_data
);
   localparam int BYTE_W = $clog2(MAX_BYTES);

   logic              clr, wr, commit;
   logic [BYTE_W-1:0] idx;
   logic [7:0]        wbyte;

   tlink_evt_match #(.SLOTS(SLOTS), .CODE_W(8)) evt_i (
      .clk(rx_clk), .rst(rx_los),
      .code(rx_word[7:0]), .code_is_k(rx_kflag[0]),
      .slot_num(evt_num), .slot_en(evt_en), .hit(evt_hit)
   );

   tlink_frame_parser #(.MAX_BYTES(MAX_BYTES), .BYTE_W(BYTE_W)) parse_i (
      .clk(rx_clk), .rst(rx_los),
      .hi_byte(rx_word[15:8]), .hi_is_k(rx_kflag[1]),
      .clr_o(clr), .wr_o(wr), .idx_o(idx), .byte_o(wbyte),
      .commit_o(commit), .err_o(frame_err)
   );

   tlink_pingpong_buf #(
      .MAX_BYTES(MAX_BYTES), .HOST_AW(HOST_AW),
      .BASE_WORD(BASE_WORD), .SYNC_STAGES(2), .BYTE_W(BYTE_W)
   ) buf_i (
      .wclk(rx_clk), .wrst(rx_los),
      .clr_i(clr), .wr_i(wr), .idx_i(idx), .byte_i(wbyte), .commit_i(commit),
      .rclk(usr_clk), .rrst(usr_rst),
      .raddr_i(host_addr), .rdata_o(host_data)
   );

   // R1: no event or error activity right after loss of signal ends
   p_quiet_reset_r1: assert property (@(posedge rx_clk)
      $past(rx_los) |-> (evt_hit == '0 && !frame_err));
endmodule

// File: tb/tlink_frame_decoder_tb_top.sv
module tlink_frame_decoder_tb_top;
   logic        rx_clk = 1'b0;
   logic        usr_clk = 1'b0;
   logic        rx_los;
   logic        usr_rst;
   logic [15:0] rx_word;
   logic [1:0]  rx_kflag;
   logic [31:0] evt_num;
   logic [3:0]  evt_en;
   logic [3:0]  evt_hit;
   logic        frame_err;
   logic [11:0] host_addr;
   logic [31:0] host_data;

   int total = 0;
   int bad = 0;
   int err_cnt = 0;

   logic [7:0] fb [80];
   logic [7:0] vis [64];
   int         vis_n = 0;

   always #10 rx_clk = ~rx_clk;
   always #7  usr_clk = ~usr_clk;

   tlink_frame_decoder dut_i (
      .rx_clk(rx_clk), .rx_los(rx_los), .rx_word(rx_word), .rx_kflag(rx_kflag),
      .evt_num(evt_num), .evt_en(evt_en), .evt_hit(evt_hit), .frame_err(frame_err),
      .usr_clk(usr_clk), .usr_rst(usr_rst), .host_addr(host_addr), .host_data(host_data)
   );

   always @(negedge rx_clk) if (!rx_los && frame_err) err_cnt++;

   // low byte, low flag, expected hit mask (slots: 0x0F, 0x21, 0x21, 0x40 disabled)
   localparam logic [12:0] EV_TAB [8] = '{
      {8'h0F, 1'b0, 4'b0001},
      {8'h21, 1'b0, 4'b0110},
      {8'h40, 1'b0, 4'b0000},
      {8'hBC, 1'b1, 4'b0000},
      {8'h0F, 1'b1, 4'b0000},
      {8'h00, 1'b0, 4'b0000},
      {8'h55, 1'b0, 4'b0000},
      {8'hBC, 1'b0, 4'b0000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rx_put(input logic [7:0] hi, input logic kh, input logic [7:0] lo, input logic kl);
      rx_word  = {hi, lo};
      rx_kflag = {kh, kl};
      @(negedge rx_clk);
   endtask

   task automatic frame_open();
      rx_put(8'h5C, 1'b1, 8'h00, 1'b0);
   endtask

   task automatic frame_byte(input logic [7:0] b);
      rx_put(8'hEE, 1'b0, 8'hBC, 1'b1);
      rx_put(b, 1'b0, 8'h00, 1'b0);
   endtask

   task automatic frame_close(input logic [15:0] cs);
      rx_put(8'hEE, 1'b0, 8'hBC, 1'b1);
      rx_put(8'h3C, 1'b1, 8'h00, 1'b0);
      rx_put(8'hEE, 1'b0, 8'hBC, 1'b1);
      rx_put(cs[15:8], 1'b0, 8'h00, 1'b0);
      rx_put(8'hEE, 1'b0, 8'hBC, 1'b1);
      rx_put(cs[7:0], 1'b0, 8'h00, 1'b0);
      repeat (4) rx_put(8'h00, 1'b0, 8'h00, 1'b0);
   endtask

   function automatic logic [15:0] good_sum(input int n);
      logic [15:0] s = '0;
      for (int i = 0; i < n; i++) s = s + 16'(fb[i]);
      return 16'hFFFF - s;
   endfunction

   task automatic send_frame(input int n, input logic [15:0] cs);
      frame_open();
      for (int i = 0; i < n; i++) frame_byte(fb[i]);
      frame_close(cs);
      repeat (10) @(negedge usr_clk);
   endtask

   task automatic accept(input int n);
      for (int i = 0; i < n; i++) vis[i] = fb[i];
      vis_n = n;
   endtask

   function automatic logic [31:0] exp_word(input int a);
      logic [31:0] w = '0;
      for (int l = 0; l < 4; l++) begin
         int k = (a - 8) * 4 + l;
         if (a >= 8 && k < vis_n) w[8*l +: 8] = vis[k];
      end
      return w;
   endfunction

   task automatic host_read(input int a, output logic [31:0] d);
      @(negedge usr_clk);
      host_addr = 12'(a);
      @(posedge usr_clk);
      @(posedge usr_clk);
      @(negedge usr_clk);
      d = host_data;
   endtask

   task automatic host_chk(input string req, input int a);
      logic [31:0] d;
      host_read(a, d);
      chk(req, d, exp_word(a));
   endtask

   initial begin
      repeat (150000) @(posedge rx_clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int e0;
      rx_los = 1'b1;
      usr_rst = 1'b1;
      rx_word = '0;
      rx_kflag = '0;
      host_addr = '0;
      evt_num = {8'h40, 8'h21, 8'h21, 8'h0F};
      evt_en = 4'b0111;
      repeat (3) @(negedge rx_clk);
      rx_put(8'h00, 1'b0, 8'h0F, 1'b0);
      chk("R1 hit in reset", {28'd0, evt_hit}, 32'd0);
      chk("R1 err in reset", {31'd0, frame_err}, 32'd0);
      rx_los = 1'b0;
      @(negedge usr_clk);
      usr_rst = 1'b0;
      @(negedge rx_clk);
      host_chk("R1 empty word 8", 8);

      // event vectors
      for (int i = 0; i < 8; i++) begin
         rx_put(8'h00, 1'b0, EV_TAB[i][12:5], EV_TAB[i][4]);
         chk($sformatf("R3/R2/R4 event vector %0d", i), {28'd0, evt_hit}, {28'd0, EV_TAB[i][3:0]});
         rx_put(8'h00, 1'b0, 8'h00, 1'b0);
         chk($sformatf("R3 one-cycle pulse %0d", i), {28'd0, evt_hit}, 32'd0);
      end
      evt_en = 4'b1000;
      rx_put(8'h00, 1'b0, 8'h40, 1'b0);
      chk("R4 enabled slot3 fires", {28'd0, evt_hit}, 32'd8);
      rx_put(8'h00, 1'b0, 8'h0F, 1'b0);
      chk("R4 disabled slot0 silent", {28'd0, evt_hit}, 32'd0);
      evt_en = 4'b0111;
      rx_put(8'h00, 1'b0, 8'h00, 1'b0);

      // frame A: 16 bytes, good
      begin
         logic [7:0] pa [16] = '{8'h02, 8'hDB, 8'h93, 8'h36, 8'h41, 8'h00, 8'h00, 8'h00,
                                8'hA3, 8'h1D, 8'h7F, 8'h33, 8'h9B, 8'hF3, 8'h51, 8'h04};
         for (int i = 0; i < 16; i++) fb[i] = pa[i];
      end
      e0 = err_cnt;
      send_frame(16, good_sum(16));
      accept(16);
      chk("R6 no error on good frame", err_cnt, e0);
      for (int a = 8; a < 12; a++) host_chk("R5/R6/R8/R11 frame A word", a);
      host_chk("R8 past frame length", 12);
      host_chk("R8 below base", 7);
      host_chk("R8 address 0", 0);

      // R10 latency
      host_read(8, d);
      @(negedge usr_clk);
      host_addr = 12'd9;
      @(posedge usr_clk);
      @(negedge usr_clk);
      chk("R10 old word after one edge", host_data, exp_word(8));
      @(posedge usr_clk);
      @(negedge usr_clk);
      chk("R10 new word after two edges", host_data, exp_word(9));

      // frame B: bad checksum
      for (int i = 0; i < 8; i++) fb[i] = 8'(8'hA0 + i);
      e0 = err_cnt;
      send_frame(8, good_sum(8) ^ 16'h0001);
      chk("R7 single error pulse", err_cnt, e0 + 1);
      host_chk("R7 view unchanged w8", 8);
      host_chk("R7 view unchanged w11", 11);

      // frame C: restart inside a frame, 5 bytes
      frame_open();
      frame_byte(8'h11);
      frame_byte(8'h22);
      frame_byte(8'h33);
      for (int i = 0; i < 5; i++) fb[i] = 8'(8'h31 + 8'(i * 3));
      e0 = err_cnt;
      send_frame(5, good_sum(5));
      accept(5);
      chk("R5 restart no error", err_cnt, e0);
      host_chk("R5 restarted frame w8", 8);
      host_chk("R8 partial word w9", 9);
      host_chk("R8 stale bytes cleared w10", 10);

      // frame D: exactly 64 bytes
      for (int i = 0; i < 64; i++) fb[i] = 8'(i) ^ 8'h5A;
      e0 = err_cnt;
      send_frame(64, good_sum(64));
      accept(64);
      chk("R9 full frame no error", err_cnt, e0);
      host_chk("R9 full frame w8", 8);
      host_chk("R9 full frame last word", 23);
      host_chk("R8 above window", 24);

      // frame E: 65 bytes, overflow
      for (int i = 0; i < 65; i++) fb[i] = 8'hC3;
      e0 = err_cnt;
      send_frame(65, good_sum(65));
      chk("R9 overflow error pulse", err_cnt, e0 + 1);
      host_chk("R9 view unchanged after overflow", 8);
      host_chk("R9 view unchanged last word", 23);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule